// File: doc/BRIEF.md
# Pre-Trigger Event Capture Buffer

This block records fixed-length windows of 14-bit ADC samples around a trigger. Samples are written into a circular store on every ADC clock, so a programmable stretch of history is always available. When the trigger rises, the block keeps that history, stores the rest of the window, freezes the store and hands the window to a second, slower read clock. The read side then streams the whole window out as one unbroken burst, with a qualifier high on every word.

Three quasi-static configuration inputs shape the capture: a 10-bit count of samples to keep from before the trigger, a 3-bit code that selects the window length, and a 2-bit selector. The selector can replace the data on the output with a generated alternating test word, which is useful for checking the link downstream. The trigger is expected to be synchronous to the ADC clock. The configuration inputs must not change while an event is in flight.

Top module: `pretrig_capture`

## Requirements
- R1: After reset `valid_o` is low and stays low until a trigger has been accepted.
- R2: The window length N follows `size_code_i`: code k (0 to 6) gives 16·2^k samples (16, 32, 64, 128, 256, 512, 1024), and code 7 also gives 1024. Each accepted trigger produces exactly N words with `valid_o` high.
- R3: The trigger sample is the `adc_data_i` value at the first rising `adc_clk_i` edge where `trig_i` is seen high after being low. The first word out is the sample taken P ADC cycles before it. With P = 0 the first word is the trigger sample itself.
- R4: P is `pre_count_i` clamped to N. When P equals N, the window ends with the sample just before the trigger sample.
- R5: Words leave in capture order, one per read clock, and `valid_o` stays high with no gap from the first word to the last.
- R6: Only a rising edge of `trig_i` starts an event. Edges that arrive while an event is being stored or read out are ignored. A level still high when the block re-arms starts nothing.
- R7: When `tp_sel_i[1]` = 1, `dout_o` carries a generated word that changes on every read clock. With `tp_sel_i[0]` = 0 the word alternates between 0x3FFF and 0x0000; with `tp_sel_i[0]` = 1 it alternates between 0x2AAA and 0x1555. `valid_o` still frames N cycles per event.
- R8: From the trigger until the readout has finished, the window start address and length stay fixed, and the write side accepts no new request.
- R9: `valid_o` first rises no later than six read-clock periods after the ADC edge that writes the last sample of the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| adc_clk_i | input | 1 | ADC sample clock (write side) |
| rd_clk_i | input | 1 | Read clock, no faster than 100 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset, released per domain through a synchronizer |
| trig_i | input | 1 | Trigger, active on its rising edge, ADC-clock synchronous |
| adc_data_i | input | 14 | ADC sample |
| pre_count_i | input | 10 | Number of samples kept from before the trigger |
| size_code_i | input | 3 | Window length code |
| tp_sel_i | input | 2 | Bit 1: pattern instead of data; bit 0: which pattern pair |
| dout_o | output | 14 | Output word |
| valid_o | output | 1 | High on each word of a window |

## Verification
The last window sample is written on a known ADC edge. The request toggle then takes two read flops to cross, one edge to load the read address, one edge for the store read, and one edge for the output register. This places the first valid word at most five read edges after the write, and the bench time-stamps both ends to hold that bound. Each later word follows on the next read edge, so the scoreboard pops one expected sample for every read cycle that has `valid_o` high, and it flags any gap or surplus word. All outputs are sampled on the falling read-clock edge, half a period after the registers update. Pattern words are checked on every read cycle only once the selector has been steady for several cycles, so the two-register output path has settled.

// File: rtl/pretrig_pkg.sv
`timescale 1ns/1ps
package pretrig_pkg;

  typedef enum logic [1:0] {
    WR_ARMED = 2'd0,
    WR_POST  = 2'd1,
    WR_HOLD  = 2'd2
  } wr_state_e;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_BURST = 1'b1
  } rd_state_e;

  // window length for a size code: 2^(code+min_log2), capped at 2^max_log2
  function automatic int unsigned event_len(input int unsigned code,
                                            input int unsigned min_log2,
                                            input int unsigned max_log2);
    int unsigned lg;
    lg = code + min_log2;
    if (lg > max_log2) lg = max_log2;
    return 32'd1 << lg;
  endfunction

endpackage

// File: rtl/pc_rst_sync.sv
`timescale 1ns/1ps
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) shift_q <= '0;
    else          shift_q <= shift_d;
  end

  assign srst_no = shift_q[STAGES-1];
endmodule

// File: rtl/pc_sample_ram.sv
`timescale 1ns/1ps
module pc_sample_ram #(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= store[raddr_i];
  end
endmodule

// File: rtl/pc_write_ctrl.sv
`timescale 1ns/1ps
module pc_write_ctrl
  import pretrig_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PRE_W    = 10,
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 4,
  localparam int LEN_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [PRE_W-1:0]  pre_count_i,
  input  logic [CODE_W-1:0] size_code_i,
  input  logic              ack_tgl_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              req_tgl_o
);
  wr_state_e         st_q, st_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              ld_window;
  logic              req_q, req_d;
  logic              trig_q;
  logic              ack_s1_q, ack_s2_q, ack_seen_q, ack_seen_d;

  logic [LEN_W-1:0]  size_len, pre_ext, pre_eff, post_len;
  logic              trig_rise, ack_evt, we;

  always_comb begin
    size_len  = LEN_W'(event_len(32'(size_code_i), MIN_LOG2, ADDR_W));
    pre_ext   = LEN_W'(pre_count_i);
    pre_eff   = (pre_ext > size_len) ? size_len : pre_ext;
    post_len  = size_len - pre_eff;
    trig_rise = trig_i & ~trig_q;
    ack_evt   = ack_s2_q != ack_seen_q;
  end

  always_comb begin
    st_d       = st_q;
    rem_d      = rem_q;
    start_d    = start_q;
    len_d      = len_q;
    ld_window  = 1'b0;
    req_d      = req_q;
    ack_seen_d = ack_seen_q;
    we         = 1'b0;
    unique case (st_q)
      WR_ARMED: begin
        we = 1'b1;
        if (trig_rise) begin
          ld_window = 1'b1;
          start_d   = wptr_q - ADDR_W'(pre_eff);
          len_d     = size_len;
          if (post_len == '0) we = 1'b0;
          if (post_len <= LEN_W'(1)) begin
            st_d  = WR_HOLD;
            req_d = ~req_q;
          end else begin
            rem_d = post_len - LEN_W'(1);
            st_d  = WR_POST;
          end
        end
      end
      WR_POST: begin
        we    = 1'b1;
        rem_d = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) begin
          st_d  = WR_HOLD;
          req_d = ~req_q;
        end
      end
      WR_HOLD: begin
        if (ack_evt) begin
          ack_seen_d = ack_s2_q;
          st_d       = WR_ARMED;
        end
      end
      default: st_d = WR_ARMED;
    endcase
    wptr_d = we ? wptr_q + ADDR_W'(1) : wptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= WR_ARMED;
      wptr_q     <= '0;
      rem_q      <= '0;
      start_q    <= '0;
      len_q      <= '0;
      req_q      <= 1'b0;
      trig_q     <= 1'b0;
      ack_s1_q   <= 1'b0;
      ack_s2_q   <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      wptr_q     <= wptr_d;
      rem_q      <= rem_d;
      if (ld_window) begin
        start_q <= start_d;
        len_q   <= len_d;
      end
      req_q      <= req_d;
      trig_q     <= trig_i;
      ack_s1_q   <= ack_tgl_i;
      ack_s2_q   <= ack_s1_q;
      ack_seen_q <= ack_seen_d;
    end
  end

  assign we_o      = we;
  assign waddr_o   = wptr_q;
  assign start_o   = start_q;
  assign len_o     = len_q;
  assign req_tgl_o = req_q;

  // R8: window description frozen outside the armed state
  assert_window_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != WR_ARMED) |=> ($stable(start_q) && $stable(len_q)));

  // R6: while holding, no second request is raised
  assert_one_request_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WR_HOLD) |=> $stable(req_q));

  // R3: the post-trigger count steps down by one per stored sample
  assert_post_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WR_POST) |=> ((st_q == WR_HOLD) || (rem_q == $past(rem_q) - LEN_W'(1))));
endmodule

// File: rtl/pc_read_ctrl.sv
`timescale 1ns/1ps
module pc_read_ctrl
  import pretrig_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 10,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] ram_q_i,
  input  logic [1:0]        tp_sel_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  function automatic logic [DATA_W-1:0] alt_word(input logic odd_set);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = ((i % 2) == 1) == odd_set;
    return v;
  endfunction

  localparam logic [DATA_W-1:0] PAT_ODD  = alt_word(1'b1);
  localparam logic [DATA_W-1:0] PAT_EVEN = alt_word(1'b0);
  localparam logic [DATA_W-1:0] PAT_HIGH = '1;
  localparam logic [DATA_W-1:0] PAT_LOW  = '0;

  rd_state_e         st_q, st_d;
  logic              req_s1_q, req_s2_q, req_seen_q, req_seen_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              ack_q, ack_d;
  logic              issue_q;
  logic              phase_q;
  logic [DATA_W-1:0] dout_q, dout_d, pat;
  logic              valid_q;
  logic              start_evt, re;

  always_comb begin
    start_evt  = req_s2_q != req_seen_q;
    st_d       = st_q;
    req_seen_d = req_seen_q;
    raddr_d    = raddr_q;
    rem_d      = rem_q;
    ack_d      = ack_q;
    re         = 1'b0;
    unique case (st_q)
      RD_IDLE: begin
        if (start_evt) begin
          req_seen_d = req_s2_q;
          raddr_d    = start_i;
          rem_d      = len_i;
          st_d       = RD_BURST;
        end
      end
      RD_BURST: begin
        re      = 1'b1;
        raddr_d = raddr_q + ADDR_W'(1);
        rem_d   = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) begin
          st_d  = RD_IDLE;
          ack_d = ~ack_q;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_comb begin
    if (tp_sel_i[0]) pat = phase_q ? PAT_EVEN : PAT_ODD;
    else             pat = phase_q ? PAT_LOW  : PAT_HIGH;
    dout_d = tp_sel_i[1] ? pat : ram_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RD_IDLE;
      req_s1_q   <= 1'b0;
      req_s2_q   <= 1'b0;
      req_seen_q <= 1'b0;
      raddr_q    <= '0;
      rem_q      <= '0;
      ack_q      <= 1'b0;
      issue_q    <= 1'b0;
      phase_q    <= 1'b0;
      dout_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      st_q       <= st_d;
      req_s1_q   <= req_tgl_i;
      req_s2_q   <= req_s1_q;
      req_seen_q <= req_seen_d;
      raddr_q    <= raddr_d;
      rem_q      <= rem_d;
      ack_q      <= ack_d;
      issue_q    <= re;
      phase_q    <= ~phase_q;
      dout_q     <= dout_d;
      valid_q    <= issue_q;
    end
  end

  assign re_o      = re;
  assign raddr_o   = raddr_q;
  assign ack_tgl_o = ack_q;
  assign dout_o    = dout_q;
  assign valid_o   = valid_q;

  // R2: a burst never runs past its length
  assert_burst_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RD_BURST) |-> (rem_q != '0));

  // R5: the qualifier drops only once the burst has finished
  assert_valid_contig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> (st_q == RD_IDLE));

  // R7: generated words change on every read clock
  assert_pattern_alt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_sel_i[1] && $past(tp_sel_i[1]) && ($past(tp_sel_i[0]) == tp_sel_i[0]))
      |=> (dout_o != $past(dout_o)));
endmodule

// File: rtl/pretrig_capture.sv
`timescale 1ns/1ps
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int DATA_W   = 14,
  parameter int ADDR_W   = 10,
  parameter int PRE_W    = 10,
  parameter int CODE_W   = 3,
  parameter int MIN_LOG2 = 4,
  localparam int LEN_W   = ADDR_W + 1
) (
  input  logic              adc_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic [PRE_W-1:0]  pre_count_i,
  input  logic [CODE_W-1:0] size_code_i,
  input  logic [1:0]        tp_sel_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic              wr_rst_n, rd_rst_n;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr, start_addr;
  logic [LEN_W-1:0]  win_len;
  logic              req_tgl, ack_tgl, re;
  logic [DATA_W-1:0] ram_q;

  pc_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk_i(adc_clk_i), .arst_ni(rst_ni), .srst_no(wr_rst_n));

  pc_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk_i(rd_clk_i), .arst_ni(rst_ni), .srst_no(rd_rst_n));

  pc_write_ctrl #(
    .ADDR_W(ADDR_W), .PRE_W(PRE_W), .CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2)
  ) u_wr (
    .clk_i(adc_clk_i), .rst_ni(wr_rst_n), .trig_i(trig_i),
    .pre_count_i(pre_count_i), .size_code_i(size_code_i),
    .ack_tgl_i(ack_tgl), .we_o(we), .waddr_o(waddr),
    .start_o(start_addr), .len_o(win_len), .req_tgl_o(req_tgl));

  pc_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i(adc_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(adc_data_i),
    .rclk_i(rd_clk_i), .re_i(re), .raddr_i(raddr), .rdata_o(ram_q));

  pc_read_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_n), .req_tgl_i(req_tgl),
    .start_i(start_addr), .len_i(win_len), .ram_q_i(ram_q),
    .tp_sel_i(tp_sel_i), .re_o(re), .raddr_o(raddr),
    .ack_tgl_o(ack_tgl), .dout_o(dout_o), .valid_o(valid_o));

  // R1: nothing is qualified while the read side is held in reset
  always_comb begin
    if (!rd_rst_n) assert_idle_in_reset_R1: assert (!valid_o);
  end
endmodule

// File: tb/pretrig_capture_bench.sv
`timescale 1ns/1ps
module pretrig_capture_bench;
  logic        adc_clk, rd_clk, rst_n, trig;
  logic [13:0] adc_data;
  logic [9:0]  pre_cnt;
  logic [2:0]  code;
  logic [1:0]  tp_sel;
  logic [13:0] dout;
  logic        valid;

  int checks, fails;
  bit done;
  logic [13:0] exp_q[$];
  int      got_words;
  realtime rise_t;
  bit      pat_chk;
  logic [13:0] pa, pb;
  logic        prev_valid;
  logic [13:0] prev_dout;

  pretrig_capture u_pretrig_capture (
    .adc_clk_i(adc_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n), .trig_i(trig),
    .adc_data_i(adc_data), .pre_count_i(pre_cnt), .size_code_i(code),
    .tp_sel_i(tp_sel), .dout_o(dout), .valid_o(valid));

  initial begin rd_clk = 0; forever #5 rd_clk = ~rd_clk; end
  initial begin adc_clk = 0; forever #3.5 adc_clk = ~adc_clk; end
  initial begin
    adc_data = '0;
    forever @(negedge adc_clk) adc_data <= adc_data + 14'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected words, checks framing and pattern words
  initial begin
    prev_valid = 0; prev_dout = '0;
    forever begin
      @(negedge rd_clk);
      if (valid) begin
        got_words++;
        if (!prev_valid && rise_t == 0) rise_t = $realtime;
        if (!tp_sel[1]) begin
          if (exp_q.size() == 0) check(0, "R6 unexpected word", int'(dout), 0);
          else begin
            logic [13:0] e;
            e = exp_q.pop_front();
            check(dout == e, "R3 R5 word order", int'(dout), int'(e));
          end
        end
      end else if (prev_valid && exp_q.size() != 0)
        check(0, "R5 gap in burst", exp_q.size(), 0);
      if (pat_chk) begin
        check(dout == pa || dout == pb, "R7 pattern value", int'(dout), int'(pa));
        check(dout != prev_dout, "R7 pattern alternates", int'(dout), int'(~prev_dout));
      end
      prev_valid = valid;
      prev_dout  = dout;
    end
  end

  task automatic run_event(input int c, input int p, input logic [1:0] sel,
                           input bit extra, input bit hold);
    int size, pe, post, guard;
    logic [13:0] t_smp;
    realtime t_trig, t_last;
    @(negedge adc_clk);
    code = 3'(c); pre_cnt = 10'(p); tp_sel = sel;
    pa = sel[0] ? 14'h2AAA : 14'h3FFF;
    pb = sel[0] ? 14'h1555 : 14'h0000;
    repeat (1100) @(negedge adc_clk);
    pat_chk = sel[1];
    size = 1 << ((c + 4 > 10) ? 10 : c + 4);
    pe   = (p > size) ? size : p;
    post = size - pe;
    @(negedge adc_clk); #1;
    t_smp = adc_data;
    trig = 1;
    got_words = 0; rise_t = 0;
    if (!sel[1])
      for (int i = 0; i < size; i++) exp_q.push_back(t_smp - 14'(pe) + 14'(i));
    @(posedge adc_clk); t_trig = $realtime;
    t_last = t_trig + ((post > 0) ? (post - 1) : 0) * 7.0;
    if (!hold) begin @(negedge adc_clk); trig = 0; end
    if (extra) begin
      repeat (3) @(negedge adc_clk);
      trig = 1;
      @(negedge adc_clk); trig = 0;
    end
    guard = 0;
    while (got_words < size && guard < 20000) begin @(negedge rd_clk); guard++; end
    repeat (40) @(negedge rd_clk);
    check(got_words == size, "R2 burst length", got_words, size);
    check(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
    check(rise_t > 0 && (rise_t - t_last) <= 65.0, "R9 readout latency",
          int'(rise_t - t_last), 60);
    if (extra) check(got_words == size, "R6 retrigger ignored", got_words, size);
    if (hold) begin
      repeat (1200) @(negedge adc_clk);
      check(got_words == size, "R6 held level starts nothing", got_words, size);
      trig = 0;
    end
    pat_chk = 0;
    exp_q.delete();
  endtask

  initial begin
    checks = 0; fails = 0; done = 0; pat_chk = 0;
    rst_n = 0; trig = 0; pre_cnt = '0; code = '0; tp_sel = '0;
    pa = '0; pb = '0; got_words = 0; rise_t = 0;
    repeat (5) @(negedge rd_clk);
    check(valid == 0, "R1 valid low in reset", valid, 0);
    rst_n = 1;
    repeat (20) @(negedge rd_clk);
    check(valid == 0, "R1 valid low after reset", valid, 0);
    check(got_words == 0, "R1 no words before trigger", got_words, 0);
    run_event(0, 4,    2'b00, 0, 0);  // R2 R3 smallest window
    run_event(2, 0,    2'b00, 0, 0);  // R3 no history
    run_event(3, 200,  2'b00, 0, 0);  // R4 clamp, trigger sample excluded
    run_event(0, 1023, 2'b00, 0, 0);  // R4 clamp
    run_event(7, 1023, 2'b00, 0, 0);  // R2 code 7 gives 1024
    run_event(6, 512,  2'b00, 0, 0);  // R2 full depth
    run_event(5, 100,  2'b00, 1, 0);  // R6 edge during storage
    run_event(1, 8,    2'b00, 0, 1);  // R6 level held through re-arm
    run_event(4, 16,   2'b00, 0, 0);  // R8 clean re-arm after readout
    run_event(1, 5,    2'b10, 0, 0);  // R7 high/low pair
    run_event(1, 5,    2'b11, 0, 0);  // R7 alternating-bit pair
    run_event(2, 10,   2'b00, 0, 0);  // R7 data path restored
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule